// File: doc/BRIEF.md
# Read Line Address Sequencer

This block produces the line index and the word index for the read side of a memory that is accessed one line at a time. Each rising clock is one of three kinds of cycle. In an access cycle the word pointer may advance. In a set cycle one bit of a starting line number is shifted in. In a reset cycle the line pointer is repositioned in a single clock.

Reset cycles are decoded from two dual-purpose pins. Depending on those pins, the line is held, returned to line 0, stepped forward, or jumped to a stored target line. Each reset cycle also returns the word pointer to 0. The stored target is written only by a completed serial load, so a return to line 0 leaves it available for a later jump.

The output enable controls only whether the data pins would be driven. It never affects pointer motion. The read strobe marks the cycles in which a word is fetched and the pointer moves on.

Top module: `rd_line_seq`

## Requirements
- R1: While reset is asserted and after it is released, `line_idx` and `word_idx` are 0 and the stored target line is 0.
- R2: A set cycle has `mode_sel`=0 and `addr_en`=1 and shifts one `line_bit` per clock, least significant bit first by default. On the ninth consecutive set cycle, both the line pointer and the stored target take the assembled value. During set cycles the line pointer is otherwise unchanged and the word pointer is 0.
- R3: A loaded value at or above LINES (default 290) is clamped to LINES-1.
- R4: A reset cycle has `mode_sel`=1. With {`line_step`,`addr_en`}=00 it keeps the line and sets the word to 0.
- R5: {`line_step`,`addr_en`}=01 sets both the line and the word to 0 and leaves the stored target unchanged.
- R6: {`line_step`,`addr_en`}=10 moves to the next line with word 0. Stepping from line LINES-1 goes to line 0.
- R7: {`line_step`,`addr_en`}=11 sets the line to the stored target and the word to 0.
- R8: An access cycle has `mode_sel`=0 and `addr_en`=0. In an access cycle the word pointer advances by one when `rd_en`=1 and stays the same when `rd_en`=0.
- R9: `out_en` has no effect on either pointer. `out_valid` equals `out_en` during access cycles and is 0 during set and reset cycles.
- R10: The word pointer stops at WORDS-1 (default 959) and does not advance further.
- R11: `rd_strobe` is 1 only in an access cycle with `rd_en`=1, and is 0 in set and reset cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read enable; moves the word pointer |
| out_en | input | 1 | Output enable; drive request for the data pins |
| mode_sel | input | 1 | High selects a reset cycle |
| line_step | input | 1 | Reset-mode select, upper bit |
| addr_en | input | 1 | Set-cycle enable, or reset-mode select lower bit |
| line_bit | input | 1 | Serial starting-line bit |
| line_idx | output | 9 | Current line |
| word_idx | output | 10 | Current word within the line |
| rd_strobe | output | 1 | Word fetch in this cycle |
| out_valid | output | 1 | Data pins driven; low means high impedance |

## Verification
`line_idx` and `word_idx` are registered. They reflect a cycle's controls one clock after that cycle, so the bench drives the controls on the falling edge and checks the pointers 1 ns after the next rising edge. `rd_strobe` and `out_valid` are combinational from the controls of the present cycle, so they are checked 1 ns after the falling-edge drive, before the rising edge consumes that cycle. A serial load takes effect at the edge that captures its ninth bit, and the line is also checked after each earlier bit to confirm that it has not moved.

// File: rtl/rd_line_seq_pkg.sv
package rd_line_seq_pkg;

  typedef enum logic [1:0] {
    RM_HOLD   = 2'b00,
    RM_ORIGIN = 2'b01,
    RM_NEXT   = 2'b10,
    RM_JUMP   = 2'b11
  } rst_mode_e;

  typedef enum logic [1:0] {
    CYC_ACCESS = 2'b00,
    CYC_SET    = 2'b01,
    CYC_RESET  = 2'b10
  } cyc_kind_e;

  function automatic int clamp_line(int v, int n);
    return (v >= n) ? n - 1 : v;
  endfunction

  function automatic int wrap_next_line(int v, int n);
    return (v >= n - 1) ? 0 : v + 1;
  endfunction

  function automatic int sat_next_word(int v, int n);
    return (v >= n - 1) ? n - 1 : v + 1;
  endfunction

endpackage

// File: rtl/rls_serial_loader.sv
module rls_serial_loader #(
  parameter int ADDR_BITS = 9,
  parameter bit LSB_FIRST = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic                 bit_in,
  output logic                 load_pulse,
  output logic [ADDR_BITS-1:0] load_val
);
  localparam int CW = $clog2(ADDR_BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(ADDR_BITS - 1);

  logic [CW-1:0]        cnt_q;
  logic [ADDR_BITS-1:0] sr_q;
  logic [ADDR_BITS-1:0] sr_nx;

  generate
    if (LSB_FIRST) begin : g_lsb
      assign sr_nx = {bit_in, sr_q[ADDR_BITS-1:1]};
    end else begin : g_msb
      assign sr_nx = {sr_q[ADDR_BITS-2:0], bit_in};
    end
  endgenerate

  assign load_pulse = shift_en && (cnt_q == LAST);
  assign load_val   = sr_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (shift_en) begin
      sr_q  <= sr_nx;
      cnt_q <= load_pulse ? '0 : cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R2
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> cnt_q == '0);

endmodule

// File: rtl/rls_line_unit.sv
module rls_line_unit
  import rd_line_seq_pkg::*;
#(
  parameter int LINES     = 290,
  parameter int ADDR_BITS = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rst_cyc,
  input  rst_mode_e            mode,
  input  logic                 load_pulse,
  input  logic [ADDR_BITS-1:0] load_val,
  output logic [ADDR_BITS-1:0] line_q,
  output logic [ADDR_BITS-1:0] target_q
);
  logic [ADDR_BITS-1:0] clamped;
  logic [ADDR_BITS-1:0] stepped;

  assign clamped = ADDR_BITS'(clamp_line(int'(load_val), LINES));
  assign stepped = ADDR_BITS'(wrap_next_line(int'(line_q), LINES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q   <= '0;
      target_q <= '0;
    end else if (load_pulse) begin
      line_q   <= clamped;
      target_q <= clamped;
    end else if (rst_cyc) begin
      unique case (mode)
        RM_HOLD:   line_q <= line_q;
        RM_ORIGIN: line_q <= '0;
        RM_NEXT:   line_q <= stepped;
        RM_JUMP:   line_q <= target_q;
        default:   line_q <= line_q;
      endcase
    end
  end

  // R3
  line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_q < ADDR_BITS'(LINES)) && (target_q < ADDR_BITS'(LINES)));

  // R4
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_cyc && mode == RM_HOLD) |=> $stable(line_q));

  // R5
  target_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_cyc && mode == RM_ORIGIN) |=> ($stable(target_q) && line_q == '0));

  // R7
  jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_cyc && mode == RM_JUMP) |=> line_q == $past(target_q));

endmodule

// File: rtl/rls_word_unit.sv
module rls_word_unit
  import rd_line_seq_pkg::*;
#(
  parameter int WORDS  = 960,
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  output logic [WORD_W-1:0] word_q
);
  logic [WORD_W-1:0] word_nx;

  assign word_nx = WORD_W'(sat_next_word(int'(word_q), WORDS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_q <= '0;
    else if (clr)    word_q <= '0;
    else if (adv)    word_q <= word_nx;
  end

  // R10
  word_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_q < WORD_W'(WORDS));

  // R8
  word_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !adv) |=> $stable(word_q));

  // R4
  word_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> word_q == '0);

endmodule

// File: rtl/rd_line_seq.sv
module rd_line_seq
  import rd_line_seq_pkg::*;
#(
  parameter int LINES     = 290,
  parameter int WORDS     = 960,
  parameter int ADDR_BITS = 9,
  parameter bit LSB_FIRST = 1'b1,
  localparam int WORD_W   = $clog2(WORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en,
  input  logic                 out_en,
  input  logic                 mode_sel,
  input  logic                 line_step,
  input  logic                 addr_en,
  input  logic                 line_bit,
  output logic [ADDR_BITS-1:0] line_idx,
  output logic [WORD_W-1:0]    word_idx,
  output logic                 rd_strobe,
  output logic                 out_valid
);
  cyc_kind_e            cyc;
  rst_mode_e            mode;
  logic                 is_access;
  logic                 is_set;
  logic                 is_reset;
  logic                 load_pulse;
  logic [ADDR_BITS-1:0] load_val;
  logic [ADDR_BITS-1:0] target;

  assign cyc       = mode_sel ? CYC_RESET : (addr_en ? CYC_SET : CYC_ACCESS);
  assign mode      = rst_mode_e'({line_step, addr_en});
  assign is_access = (cyc == CYC_ACCESS);
  assign is_set    = (cyc == CYC_SET);
  assign is_reset  = (cyc == CYC_RESET);

  assign rd_strobe = is_access && rd_en;
  assign out_valid = is_access && out_en;

  rls_serial_loader #(.ADDR_BITS(ADDR_BITS), .LSB_FIRST(LSB_FIRST)) u_loader (
    .clk(clk), .rst_n(rst_n), .shift_en(is_set), .bit_in(line_bit),
    .load_pulse(load_pulse), .load_val(load_val)
  );

  rls_line_unit #(.LINES(LINES), .ADDR_BITS(ADDR_BITS)) u_line (
    .clk(clk), .rst_n(rst_n), .rst_cyc(is_reset), .mode(mode),
    .load_pulse(load_pulse), .load_val(load_val),
    .line_q(line_idx), .target_q(target)
  );

  rls_word_unit #(.WORDS(WORDS), .WORD_W(WORD_W)) u_word (
    .clk(clk), .rst_n(rst_n), .clr(!is_access), .adv(rd_strobe),
    .word_q(word_idx)
  );

  // R9
  out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!mode_sel && !addr_en));

  // R11
  strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |-> (rd_en && !mode_sel && !addr_en));

  // R2
  set_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_set && !load_pulse) |=> $stable(line_idx));

  // R6
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_reset && mode == RM_NEXT && line_idx != ADDR_BITS'(LINES - 1))
      |=> line_idx == $past(line_idx) + 1'b1);

endmodule

// File: tb/test_rd_line_seq.sv
`timescale 1ns/1ps
module test_rd_line_seq;
  localparam int LINES = 290;
  localparam int WORDS = 960;
  localparam int NV    = 27;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_en = 0, out_en = 0, mode_sel = 0, line_step = 0, addr_en = 0, line_bit = 0;
  logic [8:0] line_idx;
  logic [9:0] word_idx;
  logic rd_strobe, out_valid;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  rd_line_seq i_rd_line_seq (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .out_en(out_en),
    .mode_sel(mode_sel), .line_step(line_step), .addr_en(addr_en),
    .line_bit(line_bit), .line_idx(line_idx), .word_idx(word_idx),
    .rd_strobe(rd_strobe), .out_valid(out_valid)
  );

  // {mode_sel, line_step, addr_en, rd_en, out_en, line_bit, line[8:0], word[9:0]}
  function automatic logic [24:0] v(logic ms, logic st, logic ae, logic re,
                                    logic oe, logic b, int ln, int wd);
    return {ms, st, ae, re, oe, b, 9'(ln), 10'(wd)};
  endfunction

  localparam logic [24:0] VEC [NV] = '{
    v(0,0,0,1,1,0, 0,1),  // R8 advance
    v(0,0,0,1,1,0, 0,2),  // R8
    v(0,0,0,0,1,0, 0,2),  // R8 frozen
    v(0,0,0,1,0,0, 0,3),  // R9 oe low still moves
    v(1,1,0,0,0,0, 1,0),  // R6 next
    v(0,0,0,1,1,0, 1,1),  // R8
    v(1,0,0,0,0,0, 1,0),  // R4 hold
    v(1,1,0,0,0,0, 2,0),  // R6
    v(1,0,1,0,0,0, 0,0),  // R5 origin
    v(1,1,1,0,0,0, 0,0),  // R7 jump to 0
    v(0,0,1,0,0,1, 0,0),  // R2 load 5, lsb first
    v(0,0,1,0,0,0, 0,0),
    v(0,0,1,0,0,1, 0,0),
    v(0,0,1,0,0,0, 0,0),
    v(0,0,1,0,0,0, 0,0),
    v(0,0,1,0,0,0, 0,0),
    v(0,0,1,0,0,0, 0,0),
    v(0,0,1,0,0,0, 0,0),
    v(0,0,1,0,0,0, 5,0),  // R2 ninth bit
    v(0,0,0,1,1,0, 5,1),
    v(0,0,0,1,1,0, 5,2),
    v(1,0,1,0,0,0, 0,0),  // R5
    v(1,1,1,0,0,0, 5,0),  // R5 R7 target kept
    v(1,1,0,0,0,0, 6,0),  // R6
    v(1,0,0,0,0,0, 6,0),  // R4
    v(0,0,0,0,0,0, 6,0),  // R8
    v(0,0,0,1,1,0, 6,1)   // R8
  };

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(logic ms, logic st, logic ae, logic re, logic oe, logic b);
    @(negedge clk);
    mode_sel = ms; line_step = st; addr_en = ae; rd_en = re; out_en = oe; line_bit = b;
    #1;
  endtask

  task automatic edge_wait();
    @(posedge clk);
    #1;
  endtask

  task automatic load_line(int val);
    for (int k = 0; k < 9; k++) begin
      drive(0, 0, 1, 0, 0, val[k]);
      edge_wait();
    end
  endtask

  initial begin
    #(4 * 200000);
    chk(1'b0, "WDOG", "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(line_idx == 0, "R1", "line in reset", line_idx, 0);
    chk(word_idx == 0, "R1", "word in reset", word_idx, 0);
    @(negedge clk);
    rst_n = 1'b1;
    edge_wait();
    chk(line_idx == 0 && word_idx == 0, "R1", "after release", line_idx + word_idx, 0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][24], VEC[i][23], VEC[i][22], VEC[i][21], VEC[i][20], VEC[i][19]);
      edge_wait();
      chk(line_idx == VEC[i][18:10], "R2-R9 vector", $sformatf("line step %0d", i),
          line_idx, VEC[i][18:10]);
      chk(word_idx == VEC[i][9:0], "R2-R9 vector", $sformatf("word step %0d", i),
          word_idx, VEC[i][9:0]);
    end

    // R9 R11 combinational outputs by cycle kind
    drive(0, 0, 0, 1, 1, 0);
    chk(rd_strobe == 1, "R11", "strobe access", rd_strobe, 1);
    chk(out_valid == 1, "R9", "valid access", out_valid, 1);
    edge_wait();
    drive(0, 0, 0, 0, 1, 0);
    chk(rd_strobe == 0, "R11", "strobe rd_en low", rd_strobe, 0);
    edge_wait();
    drive(0, 0, 0, 1, 0, 0);
    chk(out_valid == 0, "R9", "valid oe low", out_valid, 0);
    chk(rd_strobe == 1, "R11", "strobe oe low", rd_strobe, 1);
    edge_wait();
    drive(1, 1, 1, 1, 1, 0);
    chk(rd_strobe == 0, "R11", "strobe reset cycle", rd_strobe, 0);
    chk(out_valid == 0, "R9", "valid reset cycle", out_valid, 0);
    edge_wait();
    chk(line_idx == 5 && word_idx == 0, "R7", "jump again", line_idx, 5);
    drive(0, 0, 1, 1, 1, 0);
    chk(rd_strobe == 0, "R11", "strobe set cycle", rd_strobe, 0);
    chk(out_valid == 0, "R9", "valid set cycle", out_valid, 0);
    edge_wait();
    drive(1, 0, 0, 0, 0, 0);
    edge_wait();

    // R10 saturation at last word
    for (int i = 0; i < WORDS + 40; i++) begin
      drive(0, 0, 0, 1, 1, 0);
      edge_wait();
    end
    chk(word_idx == WORDS - 1, "R10", "saturated word", word_idx, WORDS - 1);
    chk(line_idx == 5, "R10", "line during run", line_idx, 5);
    drive(0, 0, 0, 1, 0, 0);
    edge_wait();
    chk(word_idx == WORDS - 1, "R10", "no wrap past end", word_idx, WORDS - 1);

    // R3 clamp, R6 wrap
    load_line(511);
    chk(line_idx == LINES - 1, "R3", "clamped load", line_idx, LINES - 1);
    chk(word_idx == 0, "R2", "word after load", word_idx, 0);
    drive(1, 1, 0, 0, 0, 0);
    edge_wait();
    chk(line_idx == 0, "R6", "wrap to line 0", line_idx, 0);
    drive(1, 1, 1, 0, 0, 0);
    edge_wait();
    chk(line_idx == LINES - 1, "R7", "jump to clamped target", line_idx, LINES - 1);
    load_line(300);
    chk(line_idx == LINES - 1, "R3", "clamp of 300", line_idx, LINES - 1);
    load_line(288);
    chk(line_idx == 288, "R2", "load 288", line_idx, 288);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule